// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind a serial memory front end and handles the programming half of a write instruction. After the front end has decoded the opcode and start address, it passes each received data byte to the block. The block collects the bytes in a page buffer. The buffer index is the low address bits, which advance after each byte and wrap around the page, while the upper address bits stay fixed for the whole instruction. When chip select rises, the front end also reports how many bits of a partial byte it has clocked in since the last byte boundary.

Programming starts only when chip select rises exactly on a byte boundary and at least one byte was received. The block then raises a busy flag for a fixed, parameterised number of clock cycles. During that interval it writes to the array every page location that was loaded and that lies below the protection boundary, one byte per cycle in ascending offset order. No erase step comes first. When the interval ends, busy drops and a one-cycle pulse clears the write-enable latch. Any other chip-select rise discards the collected bytes. While busy is high, the block ignores all new instructions.

Top module: `pgw_page_commit`

## Requirements
- R1: After reset, busy_o, mem_we_o and wel_clr_o are all 0.
- R2: A committed page writes each loaded byte to the address {upper bits of start_addr_i, offset}, one write per mem_we_o cycle, in ascending offset order, with the last value loaded at that offset.
- R3: The offset starts at the low PAGE_W bits of start_addr_i and increments by one after each byte, wrapping from PAGE-1 to 0. The upper address bits never change during an instruction.
- R4: When more than PAGE bytes are loaded in one instruction, later bytes overwrite earlier ones at the same offset, and only the final value is programmed.
- R5: A cs_rise_i pulse with bit_phase_i not equal to 0 discards the collected bytes. It raises no busy, causes no write and produces no wel_clr_o pulse.
- R6: A cs_rise_i pulse with bit_phase_i equal to 0 but with no data byte received since start_i does not start a cycle.
- R7: A legal commit holds busy_o at 1 for exactly CYCLE_CLKS consecutive clock cycles, starting in the cycle after the accepting cs_rise_i.
- R8: wel_clr_o pulses high for exactly one cycle, in the first cycle after busy_o falls, once per completed cycle.
- R9: When prot_en_i is 1, no byte is written at an address greater than or equal to prot_base_i. The busy interval still runs in full.
- R10: Offsets that were not loaded in the current instruction are not written, even if an earlier instruction loaded them.
- R11: While busy_o is 1, start_i, byte_valid_i and cs_rise_i are ignored. No second cycle follows, and no extra write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: a write instruction and its address were received |
| start_addr_i | input | ADDR_W | Start address of the instruction |
| byte_valid_i | input | 1 | Pulse: one complete data byte received |
| byte_i | input | 8 | The received data byte |
| cs_rise_i | input | 1 | Pulse: chip select went high |
| bit_phase_i | input | 3 | Bits of a partial byte clocked in when chip select rose (0 means byte boundary) |
| prot_en_i | input | 1 | Block protection active |
| prot_base_i | input | ADDR_W | Lowest protected address |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |
| wel_clr_o | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The bench builds the block with ADDR_W=12, PAGE_W=4 and CYCLE_CLKS=40. With a 16-byte page, the offset wrap and the overwrite after more than one page of data can be reached with a few dozen bytes. The short busy interval lets the exact busy length and the ignoring of instructions during busy be measured within a few hundred cycles. A 12-bit address still leaves room to place the protection boundary in the middle of a page, so a single commit covers both protected and unprotected offsets.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int PAGE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [PAGE_W-1:0] wr_idx_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o
);
    localparam int PAGE = 1 << PAGE_W;

    logic [PAGE-1:0][7:0] mem_d, mem_q;
    logic [PAGE-1:0]      vld_d, vld_q;

    always_comb begin
        mem_d = mem_q;
        vld_d = vld_q;
        if (clr_i) begin
            vld_d = '0;
        end else if (wr_en_i) begin
            mem_d[wr_idx_i] = wr_data_i;
            vld_d[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_q <= '0;
            vld_q <= '0;
        end else begin
            mem_q <= mem_d;
            vld_q <= vld_d;
        end
    end

    assign rd_data_o  = mem_q[rd_idx_i];
    assign rd_valid_o = vld_q[rd_idx_i];

    // R10
    clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (vld_q == '0));
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
    parameter int CYCLE_CLKS = 500000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic done_o,
    output logic running_o
);
    localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start_i) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_d = 1'b0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign done_o    = run_q && (cnt_q == LAST);
    assign running_o = run_q;

    // R7
    timer_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> !running_o);
endmodule

// File: rtl/pgw_page_commit.sv
module pgw_page_commit
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_W     = 8,
    parameter int CYCLE_CLKS = 500000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic              cs_rise_i,
    input  logic [2:0]        bit_phase_i,
    input  logic              prot_en_i,
    input  logic [ADDR_W-1:0] prot_base_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o,
    output logic              wel_clr_o
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int HI_W = ADDR_W - PAGE_W;

    generate
        if (CYCLE_CLKS <= PAGE) begin : g_bad_cfg
            $error("CYCLE_CLKS must exceed the page size");
        end
    endgenerate

    typedef struct packed {
        pgw_state_e        st;
        logic [HI_W-1:0]   page;
        logic [PAGE_W-1:0] ptr;
        logic              seen;
        logic [PAGE_W:0]   idx;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
        logic              wclr;
    } regs_t;

    regs_t r_d, r_q;

    logic              buf_clr, buf_wr;
    logic [7:0]        buf_rd_data;
    logic              buf_rd_vld;
    logic              tmr_start, tmr_done, tmr_run;
    logic [ADDR_W-1:0] cand;

    pgw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (buf_clr),
        .wr_en_i    (buf_wr),
        .wr_idx_i   (r_q.ptr),
        .wr_data_i  (byte_i),
        .rd_idx_i   (r_q.idx[PAGE_W-1:0]),
        .rd_data_o  (buf_rd_data),
        .rd_valid_o (buf_rd_vld)
    );

    pgw_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (tmr_start),
        .done_o    (tmr_done),
        .running_o (tmr_run)
    );

    assign cand = {r_q.page, r_q.idx[PAGE_W-1:0]};

    always_comb begin
        r_d       = r_q;
        r_d.we    = 1'b0;
        r_d.wclr  = 1'b0;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_LOAD;
                    r_d.page = start_addr_i[ADDR_W-1:PAGE_W];
                    r_d.ptr  = start_addr_i[PAGE_W-1:0];
                    r_d.seen = 1'b0;
                    buf_clr  = 1'b1;
                end
            end
            ST_LOAD: begin
                if (cs_rise_i) begin
                    if ((bit_phase_i == 3'd0) && r_q.seen) begin
                        r_d.st    = ST_PROG;
                        r_d.idx   = '0;
                        tmr_start = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (byte_valid_i) begin
                    buf_wr   = 1'b1;
                    r_d.ptr  = r_q.ptr + 1'b1;
                    r_d.seen = 1'b1;
                end
            end
            ST_PROG: begin
                if (!r_q.idx[PAGE_W]) begin
                    if (buf_rd_vld && !(prot_en_i && (cand >= prot_base_i))) begin
                        r_d.we    = 1'b1;
                        r_d.waddr = cand;
                        r_d.wdata = buf_rd_data;
                    end
                    r_d.idx = r_q.idx + 1'b1;
                end
                if (tmr_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.wclr = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st == ST_PROG);
    assign mem_we_o   = r_q.we;
    assign mem_addr_o = r_q.waddr;
    assign mem_data_o = r_q.wdata;
    assign wel_clr_o  = r_q.wclr;

    // R5
    accept_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> ($past(cs_rise_i) && ($past(bit_phase_i) == 3'd0)));
    // R9
    no_protected_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> !($past(prot_en_i) && (mem_addr_o >= $past(prot_base_i))));
    // R8
    wel_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wel_clr_o |-> ($past(busy_o) && !busy_o));
    // R11
    write_inside_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o);
    // R7
    busy_tracks_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> tmr_run);
endmodule

// File: tb/pgw_page_commit_tb_top.sv
`timescale 1ns/1ps
module pgw_page_commit_tb_top;
    localparam int AW  = 12;
    localparam int PW  = 4;
    localparam int PG  = 1 << PW;
    localparam int CYC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          byte_valid_i = 1'b0;
    logic [7:0]    byte_i = '0;
    logic          cs_rise_i = 1'b0;
    logic [2:0]    bit_phase_i = '0;
    logic          prot_en_i = 1'b0;
    logic [AW-1:0] prot_base_i = '0;
    logic          busy_o, mem_we_o, wel_clr_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW+7:0] exp_q[$];
    int  run_len = 0;
    int  last_len = 0;
    int  n_commits = 0;
    int  n_wel = 0;
    bit  prev_busy = 1'b0;
    bit  prev_wel = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pgw_page_commit #(.ADDR_W(AW), .PAGE_W(PW), .CYCLE_CLKS(CYC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .cs_rise_i(cs_rise_i),
        .bit_phase_i(bit_phase_i), .prot_en_i(prot_en_i), .prot_base_i(prot_base_i),
        .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .wel_clr_o(wel_clr_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares writes against the scoreboard and tracks busy/wel timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected write", int'({mem_addr_o, mem_data_o}), 0);
                end else begin
                    logic [AW+7:0] e;
                    e = exp_q.pop_front();
                    check({mem_addr_o, mem_data_o} == e, "R2 write addr/data",
                          int'({mem_addr_o, mem_data_o}), int'(e));
                end
            end
            if (busy_o) run_len++;
            if (prev_busy && !busy_o) begin
                last_len = run_len;
                run_len = 0;
                n_commits++;
                check(wel_clr_o == 1'b1, "R8 wel pulse at busy fall", int'(wel_clr_o), 1);
            end else if (wel_clr_o) begin
                check(1'b0, "R8 stray wel pulse", 1, 0);
            end
            if (wel_clr_o) n_wel++;
            prev_busy = busy_o;
            prev_wel  = wel_clr_o;
        end
    end

    // Driver: sends one instruction and pushes expected writes
    task automatic send_txn(input logic [AW-1:0] a, input int n, input logic [7:0] d0,
                            input logic [2:0] ph);
        logic [7:0]    eb[PG];
        bit            ev[PG];
        logic [PW-1:0] ptr;
        for (int k = 0; k < PG; k++) begin eb[k] = '0; ev[k] = 1'b0; end
        ptr = a[PW-1:0];
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid_i = 1'b1; byte_i = d0 + 8'(i);
            eb[ptr] = d0 + 8'(i); ev[ptr] = 1'b1; ptr = ptr + 1'b1;
            @(negedge clk);
        end
        byte_valid_i = 1'b0;
        cs_rise_i = 1'b1; bit_phase_i = ph;
        if (ph == 3'd0 && n > 0) begin
            for (int k = 0; k < PG; k++) begin
                logic [AW-1:0] ad;
                ad = {a[AW-1:PW], PW'(k)};
                if (ev[k] && !(prot_en_i && ad >= prot_base_i)) exp_q.push_back({ad, eb[k]});
            end
        end
        @(negedge clk);
        cs_rise_i = 1'b0; bit_phase_i = '0;
    endtask

    task automatic wait_commit(input string req);
        int c0;
        c0 = n_commits;
        while (n_commits == c0) @(negedge clk);
        check(last_len == CYC, "R7 busy length", last_len, CYC);
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic expect_no_commit(input string req);
        int c0;
        int w0;
        c0 = n_commits;
        w0 = n_wel;
        repeat (CYC + 5) @(negedge clk);
        check(n_commits == c0, req, n_commits - c0, 0);
        check(n_wel == w0, req, n_wel - w0, 0);
        check(busy_o == 1'b0, req, int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        check(mem_we_o == 1'b0, "R1 we", int'(mem_we_o), 0);
        check(wel_clr_o == 1'b0, "R1 wel", int'(wel_clr_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 simple partial page
        send_txn(12'h5A3, 4, 8'h10, 3'd0);
        check(busy_o == 1'b1, "R7 busy starts", int'(busy_o), 1);
        wait_commit("R2 all writes done");

        // R3 offset wrap within page
        send_txn(12'h12E, 5, 8'h40, 3'd0);
        wait_commit("R3 wrapped writes done");

        // R4 overflow overwrites earlier bytes
        send_txn(12'h200, 20, 8'h80, 3'd0);
        wait_commit("R4 overwrite writes done");

        // R5 non-boundary CS rise discards
        send_txn(12'h300, 3, 8'hA0, 3'd5);
        expect_no_commit("R5 no commit on partial byte");
        // discarded bytes must not reappear (R10)
        send_txn(12'h308, 1, 8'hC5, 3'd0);
        wait_commit("R10 only new byte written");

        // R6 zero data bytes
        send_txn(12'h310, 0, 8'h00, 3'd0);
        expect_no_commit("R6 no commit without data");

        // R9 protection boundary inside page
        prot_en_i = 1'b1; prot_base_i = 12'h408;
        send_txn(12'h404, 8, 8'h30, 3'd0);
        wait_commit("R9 partial protection");
        prot_base_i = 12'h000;
        send_txn(12'h420, 3, 8'h33, 3'd0);
        wait_commit("R9 fully protected still times");
        prot_en_i = 1'b0;

        // R10 stale buffer contents not written
        send_txn(12'h600, 16, 8'h01, 3'd0);
        wait_commit("R10 full page");
        send_txn(12'h609, 2, 8'hE0, 3'd0);
        wait_commit("R10 only two written");

        // R11 instructions during busy ignored
        send_txn(12'h700, 3, 8'h70, 3'd0);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 12'h710;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'hEE;
        @(negedge clk);
        byte_valid_i = 1'b0; cs_rise_i = 1'b1;
        @(negedge clk);
        cs_rise_i = 1'b0;
        wait_commit("R11 first commit");
        expect_no_commit("R11 nothing after busy");

        check(n_wel == n_commits, "R8 one wel per cycle", n_wel, n_commits);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule